// File: doc/BRIEF.md
# Phrase Playback Event Controller

This block turns byte-wide event codes, delivered by a serial command receiver, into a playback sequence for numbered speech phrases. An event selects one of 62 phrases, a stop request, or a speaker continuity test request. For each accepted phrase the block runs a framed sequence. It waits, switches the amplifier on, and waits again. It then strobes the synthesizer to start the phrase and watches for the phrase-done input. After playback it waits, switches the amplifier off, and waits once more before it returns to standby.

Each phrase carries its own playback mode and four wait settings. The block fetches them through a lookup port: it drives the current phrase number and reads the mode and the wait values back in the same cycle. There are three modes. A single-shot phrase plays once and is deaf to commands. A queued phrase loops, and a new request takes effect only at the end of the current pass. A preemptive phrase also loops, but a new request aborts the current pass at once. A parameterised prescaler derives a millisecond tick from the system clock. Each wait setting counts four ticks per unit.

Top module: `phrase_sequencer`

## Requirements
- R1: After reset busy_n is 1, amp_en is 0, and play_start, play_abort and diag_req are 0.
- R2: In standby a valid code from 0x02 to 0x3F is accepted, and busy_n is 0 from the next cycle on.
- R3: The wait settings sit in cfg_waits in this order: pre-amp at bits [7:0], pre-play at [15:8], post-play at [23:16] and post-amp at [31:24]. A wait phase with setting v lasts 4·v·CLK_PER_MS + 2 clock cycles. The pre-amp phase runs from the busy_n fall to the amp_en rise. The pre-play phase runs from the amp_en rise to the first play_start. The post-play phase runs from the cycle in which the block consumes play_done or a stop to the amp_en fall. The post-amp phase runs from the amp_en fall to the busy_n rise.
- R4: On entering playback the block gives a one-cycle play_start pulse with play_phrase equal to the phrase number. amp_en is 1 throughout playback.
- R5: cfg_mode 2'b00 and 2'b11 mean single-shot. The phrase plays once, every event during playback is ignored (including stop and new phrases), and play_done leads to the post-play phase.
- R6: cfg_mode 2'b01 means queued. On play_done the phrase restarts unless a request is pending. A stop or phrase request during playback is held until play_done, and a later request replaces an earlier one. A pending phrase then starts without an abort. A pending stop leads to the post-play phase.
- R7: cfg_mode 2'b10 means preemptive. On play_done the phrase restarts. A phrase request during playback gives play_abort and play_start together in the next cycle, with the new number. A stop request gives play_abort and leads to the post-play phase.
- R8: Codes 0x40 to 0xFF are ignored in every state, and stop (0x00) is ignored in standby.
- R9: Code 0x01 in standby gives a one-cycle diag_req pulse, and busy_n stays 1.
- R10: Events that arrive during any of the four wait phases are ignored.
- R11: busy_n is 1 only in standby. It returns to 1 at the end of the post-amp phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event code strobe, one cycle per event |
| evt_code | input | CODE_W | Event code |
| cfg_phrase | output | PH_W | Phrase number presented to the settings lookup |
| cfg_mode | input | 2 | Playback mode of cfg_phrase |
| cfg_waits | input | 4*WAIT_W | Four wait settings of cfg_phrase, pre-amp in the low byte |
| play_done | input | 1 | Synthesizer finished the current pass |
| busy_n | output | 1 | Low while an event is being executed |
| amp_en | output | 1 | Amplifier enable |
| play_start | output | 1 | One-cycle start strobe to the synthesizer |
| play_abort | output | 1 | One-cycle abort strobe to the synthesizer |
| play_phrase | output | PH_W | Phrase number for the synthesizer |
| diag_req | output | 1 | One-cycle speaker continuity test request |

## Verification
The bench builds the block with CLK_PER_MS = 3 and keeps the default code, phrase and wait widths. A wait setting of v therefore takes only 12·v + 2 cycles, so exact phase lengths can be measured for settings from 0 to 6 in a few hundred cycles. With the real 62-phrase code space intact, both ends of the phrase range (0x02 and 0x3F) and the first invalid code (0x40) are exercised. A short synthesizer model that signals completion 20 cycles after each start lets the queued and preemptive modes loop several times within one test.

// File: rtl/phrase_seq_pkg.sv
package phrase_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE_AMP,
      ST_PRE_PLAY,
      ST_PLAY,
      ST_POST_PLAY,
      ST_POST_AMP
   } seq_state_t;

   typedef enum logic [1:0] {
      EV_NONE,
      EV_STOP,
      EV_DIAG,
      EV_PHRASE
   } evt_kind_t;

   localparam logic [1:0] MD_SINGLE  = 2'b00;
   localparam logic [1:0] MD_QUEUED  = 2'b01;
   localparam logic [1:0] MD_PREEMPT = 2'b10;

   localparam int unsigned N_WAIT_PHASES = 4;

endpackage

// File: rtl/evt_classifier.sv
module evt_classifier
   import phrase_seq_pkg::*;
#(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned PH_W   = 6
) (
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output evt_kind_t         kind,
   output logic [PH_W-1:0]   phrase
);
   localparam int unsigned HI_W = CODE_W - PH_W;

   logic [HI_W-1:0] hi_part;
   logic [PH_W-1:0] lo_part;

   assign hi_part = code[CODE_W-1:PH_W];
   assign lo_part = code[PH_W-1:0];
   assign phrase  = lo_part;

   always_comb begin
      kind = EV_NONE;
      if (valid && (hi_part == '0)) begin
         if (lo_part == PH_W'(0))
            kind = EV_STOP;
         else if (lo_part == PH_W'(1))
            kind = EV_DIAG;
         else
            kind = EV_PHRASE;
      end
   end
endmodule

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
   parameter int unsigned CLK_PER_MS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLK_PER_MS == 1) begin : g_direct
         logic alive;
         always_ff @(posedge clk) begin
            if (!rst_n) alive <= 1'b0;
            else        alive <= 1'b1;
         end
         assign tick = alive & ~clr;
      end else begin : g_count
         localparam int unsigned PW = $clog2(CLK_PER_MS);
         localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);
         logic [PW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)    div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                  div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST) & ~clr;
      end
   endgenerate
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
   parameter int unsigned WAIT_W   = 8,
   parameter int unsigned STEP_MS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [WAIT_W-1:0] ld_val,
   input  logic              tick,
   output logic              done
);
   localparam int unsigned CNT_W = WAIT_W + $clog2(STEP_MS) + 1;

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (ld)
         left_q <= CNT_W'(ld_val) * CNT_W'(STEP_MS);
      else if (tick && (left_q != '0))
         left_q <= left_q - 1'b1;
   end

   assign done = (left_q == '0) && !ld;
endmodule

// File: rtl/phrase_sequencer.sv
module phrase_sequencer
   import phrase_seq_pkg::*;
#(
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned PH_W       = 6,
   parameter int unsigned WAIT_W     = 8,
   parameter int unsigned STEP_MS    = 4,
   parameter int unsigned CLK_PER_MS = 4096
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_valid,
   input  logic [CODE_W-1:0]     evt_code,
   output logic [PH_W-1:0]       cfg_phrase,
   input  logic [1:0]            cfg_mode,
   input  logic [4*WAIT_W-1:0]   cfg_waits,
   input  logic                  play_done,
   output logic                  busy_n,
   output logic                  amp_en,
   output logic                  play_start,
   output logic                  play_abort,
   output logic [PH_W-1:0]       play_phrase,
   output logic                  diag_req
);
   localparam int unsigned IDX_W = $clog2(N_WAIT_PHASES);

   generate
      if (CODE_W <= PH_W) begin : g_bad_code_w
         $error("CODE_W must exceed PH_W");
      end
      if (CLK_PER_MS < 1) begin : g_bad_div
         $error("CLK_PER_MS must be at least 1");
      end
      if (STEP_MS < 1) begin : g_bad_step
         $error("STEP_MS must be at least 1");
      end
      if (WAIT_W < 1) begin : g_bad_wait_w
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   seq_state_t      state_q;
   logic            enter_q;
   logic [PH_W-1:0] cur_q;
   logic            pend_vld_q, pend_stop_q;
   logic [PH_W-1:0] pend_ph_q;
   logic            start_q, abort_q, diag_q;

   evt_kind_t       kind;
   logic [PH_W-1:0] evt_ph;

   logic [WAIT_W-1:0] wait_arr [N_WAIT_PHASES];
   logic [IDX_W-1:0]  phase_idx;
   logic              in_wait, timer_ld, timer_done, ms_tick;

   logic              req_now, eff_vld, eff_stop;
   logic [PH_W-1:0]   eff_ph;

   evt_classifier #(.CODE_W(CODE_W), .PH_W(PH_W)) u_class (
      .valid  (evt_valid),
      .code   (evt_code),
      .kind   (kind),
      .phrase (evt_ph)
   );

   for (genvar k = 0; k < N_WAIT_PHASES; k++) begin : g_wait_slice
      assign wait_arr[k] = cfg_waits[k*WAIT_W +: WAIT_W];
   end

   always_comb begin
      phase_idx = '0;
      in_wait   = 1'b1;
      unique case (state_q)
         ST_PRE_AMP:   phase_idx = IDX_W'(0);
         ST_PRE_PLAY:  phase_idx = IDX_W'(1);
         ST_POST_PLAY: phase_idx = IDX_W'(2);
         ST_POST_AMP:  phase_idx = IDX_W'(3);
         default:      in_wait   = 1'b0;
      endcase
   end

   assign timer_ld = enter_q & in_wait;

   ms_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (timer_ld),
      .tick  (ms_tick)
   );

   wait_timer #(.WAIT_W(WAIT_W), .STEP_MS(STEP_MS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (timer_ld),
      .ld_val (wait_arr[phase_idx]),
      .tick   (ms_tick),
      .done   (timer_done)
   );

   // queued mode: a request in the same cycle as play_done wins over the held one
   always_comb begin
      req_now  = (kind == EV_PHRASE) || (kind == EV_STOP);
      eff_vld  = req_now | pend_vld_q;
      eff_stop = req_now ? (kind == EV_STOP) : pend_stop_q;
      eff_ph   = req_now ? evt_ph : pend_ph_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         enter_q     <= 1'b0;
         cur_q       <= '0;
         pend_vld_q  <= 1'b0;
         pend_stop_q <= 1'b0;
         pend_ph_q   <= '0;
         start_q     <= 1'b0;
         abort_q     <= 1'b0;
         diag_q      <= 1'b0;
      end else begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
         diag_q  <= 1'b0;
         enter_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (kind == EV_PHRASE) begin
                  cur_q      <= evt_ph;
                  pend_vld_q <= 1'b0;
                  state_q    <= ST_PRE_AMP;
                  enter_q    <= 1'b1;
               end else if (kind == EV_DIAG) begin
                  diag_q <= 1'b1;
               end
            end
            ST_PRE_AMP: begin
               if (timer_done) begin
                  state_q <= ST_PRE_PLAY;
                  enter_q <= 1'b1;
               end
            end
            ST_PRE_PLAY: begin
               if (timer_done) begin
                  state_q <= ST_PLAY;
                  start_q <= 1'b1;
               end
            end
            ST_PLAY: begin
               if (cfg_mode == MD_PREEMPT) begin
                  if (kind == EV_PHRASE) begin
                     abort_q <= 1'b1;
                     start_q <= 1'b1;
                     cur_q   <= evt_ph;
                  end else if (kind == EV_STOP) begin
                     abort_q <= 1'b1;
                     state_q <= ST_POST_PLAY;
                     enter_q <= 1'b1;
                  end else if (play_done) begin
                     start_q <= 1'b1;
                  end
               end else if (cfg_mode == MD_QUEUED) begin
                  if (play_done) begin
                     pend_vld_q <= 1'b0;
                     if (eff_vld && eff_stop) begin
                        state_q <= ST_POST_PLAY;
                        enter_q <= 1'b1;
                     end else begin
                        if (eff_vld) cur_q <= eff_ph;
                        start_q <= 1'b1;
                     end
                  end else if (req_now) begin
                     pend_vld_q  <= 1'b1;
                     pend_stop_q <= (kind == EV_STOP);
                     pend_ph_q   <= evt_ph;
                  end
               end else begin
                  if (play_done) begin
                     state_q <= ST_POST_PLAY;
                     enter_q <= 1'b1;
                  end
               end
            end
            ST_POST_PLAY: begin
               if (timer_done) begin
                  state_q <= ST_POST_AMP;
                  enter_q <= 1'b1;
               end
            end
            ST_POST_AMP: begin
               if (timer_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cfg_phrase  = cur_q;
   assign play_phrase = cur_q;
   assign play_start  = start_q;
   assign play_abort  = abort_q;
   assign diag_req    = diag_q;
   assign busy_n      = (state_q == ST_IDLE);
   assign amp_en      = (state_q == ST_PRE_PLAY) || (state_q == ST_PLAY) ||
                        (state_q == ST_POST_PLAY);
endmodule

// File: rtl/phrase_seq_checker.sv
module phrase_seq_checker #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned PH_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [CODE_W-1:0] evt_code,
   input logic [1:0]        cfg_mode,
   input logic              busy_n,
   input logic              amp_en,
   input logic              play_start,
   input logic              play_abort,
   input logic              diag_req
);
   logic code_is_phrase, code_is_high;
   assign code_is_high   = (evt_code >> PH_W) != '0;
   assign code_is_phrase = !code_is_high && (evt_code >= CODE_W'(2));

   AST_ACCEPT_PHRASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && evt_valid && code_is_phrase) |=> !busy_n);                // R2
   AST_START_WITH_AMP: assert property (@(posedge clk) disable iff (!rst_n)
      play_start |-> amp_en);                                               // R4
   AST_ABORT_PREEMPT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      play_abort |-> ($past(cfg_mode) == 2'b10));                           // R7
   AST_ABORT_WITH_AMP: assert property (@(posedge clk) disable iff (!rst_n)
      play_abort |-> amp_en);                                               // R7
   AST_HIGH_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && evt_valid && code_is_high) |=> busy_n);                    // R8
   AST_DIAG_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      diag_req |-> busy_n);                                                 // R9
   AST_AMP_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      amp_en |-> !busy_n);                                                  // R11
endmodule

bind phrase_sequencer phrase_seq_checker #(.CODE_W(CODE_W), .PH_W(PH_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_valid  (evt_valid),
   .evt_code   (evt_code),
   .cfg_mode   (cfg_mode),
   .busy_n     (busy_n),
   .amp_en     (amp_en),
   .play_start (play_start),
   .play_abort (play_abort),
   .diag_req   (diag_req)
);

// File: tb/phrase_sequencer_tb_top.sv
`timescale 1ns/1ps
module phrase_sequencer_tb_top;
   localparam int P   = 3;
   localparam int LEN = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [7:0]  evt_code = 8'h00;
   logic [5:0]  cfg_phrase;
   logic [1:0]  cfg_mode;
   logic [31:0] cfg_waits;
   logic        play_done = 1'b0;
   logic        busy_n, amp_en, play_start, play_abort, diag_req;
   logic [5:0]  play_phrase;

   logic [1:0]  mode_tab [64];
   logic [31:0] wait_tab [64];

   always #4 clk = ~clk;

   assign cfg_mode  = mode_tab[cfg_phrase];
   assign cfg_waits = wait_tab[cfg_phrase];

   phrase_sequencer #(.CLK_PER_MS(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .cfg_phrase(cfg_phrase), .cfg_mode(cfg_mode), .cfg_waits(cfg_waits),
      .play_done(play_done), .busy_n(busy_n), .amp_en(amp_en),
      .play_start(play_start), .play_abort(play_abort),
      .play_phrase(play_phrase), .diag_req(diag_req)
   );

   // synthesizer model and observation counters
   int cyc = 0, syn_cnt = 0;
   int n_start = 0, n_abort = 0, n_both = 0, n_done = 0, n_diag = 0, n_bfall = 0;
   int t_bf = 0, t_ar = 0, t_s1 = 0, t_done = 0, t_af = 0, t_br = 0;
   bit first_pend = 0, prev_busy = 1, prev_amp = 0;
   logic [5:0] last_ph = '0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (play_done) begin n_done <= n_done + 1; t_done <= cyc; end
      if (play_start) begin
         n_start <= n_start + 1;
         last_ph <= play_phrase;
         if (first_pend) begin t_s1 <= cyc; first_pend <= 0; end
      end
      if (play_abort) n_abort <= n_abort + 1;
      if (play_abort && play_start) n_both <= n_both + 1;
      if (diag_req) n_diag <= n_diag + 1;
      if (prev_busy && !busy_n) begin n_bfall <= n_bfall + 1; t_bf <= cyc; first_pend <= 1; end
      if (!prev_busy && busy_n) t_br <= cyc;
      if (!prev_amp && amp_en) t_ar <= cyc;
      if (prev_amp && !amp_en) t_af <= cyc;
      prev_busy <= busy_n;
      prev_amp  <= amp_en;
      if (play_start) syn_cnt <= LEN;
      else if (play_abort) syn_cnt <= 0;
      else if (syn_cnt != 0) syn_cnt <= syn_cnt - 1;
      play_done <= (syn_cnt == 1) && !play_start && !play_abort;
   end

   int total = 0, bad = 0;
   bit ended = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run;
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic send(input logic [7:0] code);
      @(negedge clk); evt_valid = 1'b1; evt_code = code;
      @(negedge clk); evt_valid = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int k;
      k = 0;
      @(negedge clk);
      while (!busy_n && k < 5000) begin @(negedge clk); k++; end
      repeat (2) @(negedge clk);
      chk({req, " standby reached"}, int'(busy_n), 1);
   endtask

   task automatic wait_starts(input int target, input string req);
      int k;
      k = 0;
      while (n_start < target && k < 5000) begin @(negedge clk); k++; end
      chk({req, " start count reached"}, n_start, target);
   endtask

   function automatic int plen(input int v);
      return 4 * v * P + 2;
   endfunction

   // phrase, mode, pre-amp, pre-play, post-play, post-amp
   localparam logic [47:0] VEC [4] = '{
      48'h02_00_00_00_00_00,
      48'h3F_00_01_02_03_04,
      48'h11_00_05_00_02_01,
      48'h28_03_03_01_00_06
   };

   initial begin
      for (int i = 0; i < 64; i++) begin mode_tab[i] = 2'b00; wait_tab[i] = '0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy_n", int'(busy_n), 1);
      chk("R1 amp_en", int'(amp_en), 0);
      chk("R1 strobes", int'(play_start | play_abort | diag_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 busy_n after release", int'(busy_n), 1);

      // table walk: single-shot phrases with varied waits
      for (int r = 0; r < 4; r++) begin
         int ph, b;
         ph = int'(VEC[r][47:40]);
         mode_tab[ph] = VEC[r][33:32];
         wait_tab[ph] = {VEC[r][7:0], VEC[r][15:8], VEC[r][23:16], VEC[r][31:24]};
         b = n_start;
         send(VEC[r][47:40]);
         wait_idle("R11");
         chk("R2 accepted", n_bfall, r + 1);
         chk("R3 pre-amp length", t_ar - t_bf, plen(int'(VEC[r][31:24])));
         chk("R3 pre-play length", t_s1 - t_ar, plen(int'(VEC[r][23:16])));
         chk("R3 post-play length", t_af - t_done, plen(int'(VEC[r][15:8])));
         chk("R3 R11 post-amp length", t_br - t_af, plen(int'(VEC[r][7:0])));
         chk("R4 one start", n_start - b, 1);
         chk("R4 phrase number", int'(last_ph), ph);
      end

      // R8 invalid codes and stop in standby
      begin
         int bf;
         bf = n_bfall;
         send(8'h40); send(8'hFF); send(8'h00);
         repeat (3) @(negedge clk);
         chk("R8 no acceptance", n_bfall - bf, 0);
         chk("R8 busy_n", int'(busy_n), 1);
      end

      // R9 diagnostic request
      begin
         int bf, d;
         bf = n_bfall; d = n_diag;
         send(8'h01);
         repeat (2) @(negedge clk);
         chk("R9 diag pulse", n_diag - d, 1);
         chk("R9 stays standby", n_bfall - bf, 0);
      end

      // R5 single-shot ignores events during playback
      begin
         int b, a;
         mode_tab[5] = 2'b00; wait_tab[5] = '0;
         b = n_start; a = n_abort;
         send(8'h05);
         wait_starts(b + 1, "R5");
         send(8'h00); send(8'h07);
         wait_idle("R5");
         chk("R5 single pass", n_start - b, 1);
         chk("R5 no abort", n_abort - a, 0);
         chk("R5 phrase kept", int'(last_ph), 5);
      end

      // R6 queued mode: repeat, held request, last one wins, stop at end of pass
      begin
         int b, a;
         mode_tab[9] = 2'b01; mode_tab[10] = 2'b01; mode_tab[11] = 2'b01;
         b = n_start; a = n_abort;
         send(8'h09);
         wait_starts(b + 2, "R6 repeat");
         chk("R6 repeat phrase", int'(last_ph), 9);
         send(8'h0A); send(8'h0B);
         repeat (2) @(negedge clk);
         chk("R6 held until pass end", n_start - b, 2);
         wait_starts(b + 3, "R6 change");
         chk("R6 later request wins", int'(last_ph), 11);
         send(8'h00);
         wait_idle("R6");
         chk("R6 no abort", n_abort - a, 0);
         chk("R6 final pass completed", n_done, n_start);
      end

      // R7 preemptive mode: immediate change and immediate stop
      begin
         int b, a, bo;
         mode_tab[20] = 2'b10; mode_tab[21] = 2'b10;
         b = n_start; a = n_abort; bo = n_both;
         send(8'h14);
         wait_starts(b + 2, "R7 repeat");
         send(8'h15);
         repeat (2) @(negedge clk);
         chk("R7 abort with start", n_both - bo, 1);
         chk("R7 new phrase", int'(last_ph), 21);
         chk("R7 start count", n_start - b, 3);
         send(8'h00);
         repeat (2) @(negedge clk);
         chk("R7 stop aborts", n_abort - a, 2);
         wait_idle("R7");
         chk("R7 no restart after stop", n_start - b, 3);
      end

      // R10 events during a wait phase
      begin
         int b;
         mode_tab[30] = 2'b10; wait_tab[30] = 32'h0000_0003;
         b = n_start;
         send(8'h1E);
         send(8'h00); send(8'h05);
         chk("R10 still before playback", int'(amp_en), 0);
         wait_starts(b + 1, "R10");
         chk("R10 phrase unchanged", int'(last_ph), 30);
         send(8'h00);
         wait_idle("R10");
      end

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      finish_run();
   end
endmodule